// File: doc/BRIEF.md
# Decoder Input FIFO Refill Event Generator

This block watches a 32-word branch-metric input FIFO that a decoder core drains. Each time one segment of that FIFO has been read empty, it raises a one-clock refill request so that a DMA engine can write that segment again. A segment is either one half (16 words of 64 bits) or one quarter (8 words) of the FIFO. The segment size comes from the product of the code rate and a 4-bit length code, and is fixed when a start pulse is seen.

When a start pulse arrives, all counters are cleared and the configuration is captured. The block then requests enough segments to fill the empty FIFO. After that it requests one segment for each segment the decoder drains. It keeps a running count of the words it has requested. Once that count reaches the total number of words the frame needs, it raises no further requests, even if the FIFO is partly empty when processing ends.

Top module: `fifo_evt_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `evt_o`, `seg_words_o`, `quad_mode_o` and `cfg_err_o` are all 0 at the next sample.
- R2: At start, the words per event are (`len_code_i`+1) times a rate multiplier. `rate_sel_i` 0 is rate 1/2 (x1), 1 is rate 1/3 (x2) and 2 is rate 1/4 (x4). A result of 16 shows `seg_words_o`=16 and `quad_mode_o`=0. A result of 8 shows `seg_words_o`=8 and `quad_mode_o`=1. These values hold from the cycle after start.
- R3: `rate_sel_i`=3, or a product other than 8 or 16, sets `cfg_err_o`=1 and `seg_words_o`=0, and no event is raised until the next start.
- R4: In half mode, a start raises 2 events as long as the frame total covers them.
- R5: In quarter mode, a start raises 4 events as long as the frame total covers them. The first event is visible in the cycle after the first clock edge that follows the start edge.
- R6: The read that completes a drained segment is followed by one event. That event is visible after the second clock edge counted from that read's edge. A partly drained segment raises nothing.
- R7: An event is raised only while the words already requested are below `frame_words_i`. A frame therefore gets at most ceil(frame/segment) events in total, and a frame total of 0 gets none.
- R8: `evt_o` is never high in two consecutive cycles.
- R9: A read strobe while the FIFO holds no words is ignored: it does not count towards draining a segment.
- R10: A new start clears all counters and raises the initial events again. `evt_o` is low in the cycle after a start.
- R11: No event is raised after reset until the first start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Frame start pulse; captures configuration |
| rate_sel_i | input | 2 | Code rate: 0=1/2, 1=1/3, 2=1/4, 3=reserved |
| len_code_i | input | 4 | Per-event length code (length minus one) |
| frame_words_i | input | 16 | Total 64-bit words the frame needs |
| wr_i | input | 1 | FIFO word written |
| rd_i | input | 1 | FIFO word read by the decoder |
| evt_o | output | 1 | One-clock refill request |
| seg_words_o | output | 5 | Words per event (8, 16, or 0 when invalid or idle) |
| quad_mode_o | output | 1 | 1 when the FIFO runs as four quarters |
| cfg_err_o | output | 1 | Captured configuration is invalid |

## Verification
On every cycle the assertions check four things: that each event stays a single-cycle pulse, that no event appears before the first start or in the cycle after any start, and that no event is raised once the requested words have reached the captured frame total. They also check that an invalid configuration stays silent and that the segment size and mode outputs agree. The bench scenarios are needed for the rest. Only they show the exact number of events after a start for each legal rate and length pair, and the two-edge delay from a completed segment drain to its event. They also show that reads on an empty FIFO and partly drained segments raise nothing, and that a restart in the middle of a frame issues the initial burst again.

// File: rtl/fifo_evt_pkg.sv
// Shared definitions for the FIFO refill event generator.
// Assumes a 4-bit length code; product width leaves room for code 15 times 4.
package fifo_evt_pkg;
    localparam int CODE_W = 4;
    localparam int PROD_W = CODE_W + 3;

    typedef enum logic [1:0] {
        RATE_HALF    = 2'd0,
        RATE_THIRD   = 2'd1,
        RATE_QUARTER = 2'd2,
        RATE_RSVD    = 2'd3
    } rate_e;

    typedef struct packed {
        logic              ok;     // product is a legal segment size
        logic              quad;   // segment is one quarter of the FIFO
        logic [PROD_W-1:0] words;  // words per event, 0 when not ok
    } seg_cfg_t;
endpackage

// File: rtl/fevt_cfg_decode.sv
// Turns code rate and length code into a segment description.
// Assumes DEPTH divisible by 4; legal sizes are DEPTH/2 and DEPTH/4.
module fevt_cfg_decode
    import fifo_evt_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic [1:0]        rate_i,
    input  logic [CODE_W-1:0] code_i,
    output seg_cfg_t          cfg_o
);
    localparam logic [PROD_W-1:0] HALF_W    = PROD_W'(DEPTH / 2);
    localparam logic [PROD_W-1:0] QUARTER_W = PROD_W'(DEPTH / 4);

    logic [PROD_W-1:0] base;
    logic [PROD_W-1:0] prod;
    logic              legal;

    // Scale (code + 1) by the rate multiplier and judge the result.
    always_comb begin
        base = PROD_W'(code_i) + PROD_W'(1);
        unique case (rate_e'(rate_i))
            RATE_HALF:    prod = base;
            RATE_THIRD:   prod = base << 1;
            RATE_QUARTER: prod = base << 2;
            default:      prod = '0;
        endcase
        legal       = (prod == HALF_W) || (prod == QUARTER_W);
        cfg_o.ok    = legal;
        cfg_o.quad  = legal && (prod == QUARTER_W);
        cfg_o.words = legal ? prod : '0;
    end
endmodule

// File: rtl/fevt_drain_track.sv
// Tracks FIFO fill level and reads within the current segment.
// Flags the read that completes a segment. Reads on an empty FIFO and
// writes on a full FIFO are ignored. Assumes seg_words_i is 0 when idle.
module fevt_drain_track
    import fifo_evt_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [PROD_W-1:0] seg_words_i,
    output logic              seg_done_o
);
    localparam int FILL_W  = $clog2(DEPTH + 1);
    localparam int DRAIN_W = $clog2(DEPTH);

    logic [FILL_W-1:0]  fill_q;
    logic [DRAIN_W-1:0] drain_q;
    logic               rd_ok;
    logic               wr_ok;
    logic               last_rd;

    // Qualify strobes against the fill level and detect segment completion.
    always_comb begin
        rd_ok   = rd_i && (fill_q != '0);
        wr_ok   = wr_i && (fill_q != FILL_W'(DEPTH));
        last_rd = rd_ok && (seg_words_i != '0) &&
                  (PROD_W'(drain_q) == seg_words_i - PROD_W'(1));
        seg_done_o = last_rd;
    end

    // Fill level: writes in, reads out.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            fill_q <= '0;
        end else begin
            unique case ({wr_ok, rd_ok})
                2'b10:   fill_q <= fill_q + FILL_W'(1);
                2'b01:   fill_q <= fill_q - FILL_W'(1);
                default: fill_q <= fill_q;
            endcase
        end
    end

    // Position of the next read inside the current segment.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            drain_q <= '0;
        end else if (rd_ok) begin
            drain_q <= last_rd ? '0 : drain_q + DRAIN_W'(1);
        end
    end
endmodule

// File: rtl/fevt_sched.sv
// Issues refill events from a pool of free segments, one pulse at a time
// with a gap in between, and stops once the requested words reach the
// frame total. Assumes the config inputs stay stable between starts.
module fevt_sched
    import fifo_evt_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int DEPTH   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               new_ok_i,
    input  logic               new_quad_i,
    input  seg_cfg_t           cur_cfg_i,
    input  logic [FRAME_W-1:0] frame_words_i,
    input  logic               seg_done_i,
    output logic               evt_o
);
    localparam int QUARTERS = 4;
    localparam int HALVES   = 2;
    localparam int PEND_W   = $clog2(QUARTERS + 1);
    localparam int REQ_W    = FRAME_W + 1;

    logic               active_q;
    logic               evt_q;
    logic [FRAME_W-1:0] frame_q;
    logic [REQ_W-1:0]   req_q;
    logic [PEND_W-1:0]  pend_q;
    logic [PEND_W-1:0]  pend_cap;
    logic [PEND_W-1:0]  pend_left;
    logic [PEND_W-1:0]  pend_nxt;
    logic               fire;

    // Decide whether to issue an event this cycle and update free segments.
    always_comb begin
        pend_cap  = cur_cfg_i.quad ? PEND_W'(QUARTERS) : PEND_W'(HALVES);
        fire      = active_q && cur_cfg_i.ok && !evt_q && (pend_q != '0) &&
                    (req_q < REQ_W'(frame_q));
        pend_left = pend_q - PEND_W'(fire);
        pend_nxt  = (seg_done_i && (pend_left != pend_cap)) ?
                    pend_left + PEND_W'(1) : pend_left;
    end

    // Capture the frame at start; otherwise count requests and issue pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            evt_q    <= 1'b0;
            frame_q  <= '0;
            req_q    <= '0;
            pend_q   <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            evt_q    <= 1'b0;
            frame_q  <= frame_words_i;
            req_q    <= '0;
            pend_q   <= !new_ok_i   ? '0 :
                        new_quad_i  ? PEND_W'(QUARTERS) : PEND_W'(HALVES);
        end else begin
            evt_q  <= fire;
            pend_q <= pend_nxt;
            if (fire) begin
                req_q <= req_q + REQ_W'(cur_cfg_i.words);
            end
        end
    end

    assign evt_o = evt_q;
endmodule

// File: rtl/fifo_evt_gen.sv
// Top of the FIFO refill event generator: decodes the segment size,
// captures it at start, tracks draining and schedules refill events.
// Assumes a synchronous active-low reset and a single-cycle start pulse.
module fifo_evt_gen
    import fifo_evt_pkg::*;
#(
    parameter  int DEPTH   = 32,
    parameter  int FRAME_W = 16,
    localparam int SEG_W   = $clog2(DEPTH / 2) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [1:0]         rate_sel_i,
    input  logic [CODE_W-1:0]  len_code_i,
    input  logic [FRAME_W-1:0] frame_words_i,
    input  logic               wr_i,
    input  logic               rd_i,
    output logic               evt_o,
    output logic [SEG_W-1:0]   seg_words_o,
    output logic               quad_mode_o,
    output logic               cfg_err_o
);
    seg_cfg_t dec_cfg;
    seg_cfg_t cfg_q;
    logic     err_q;
    logic     seg_done;

    fevt_cfg_decode #(.DEPTH(DEPTH)) u_decode (
        .rate_i (rate_sel_i),
        .code_i (len_code_i),
        .cfg_o  (dec_cfg)
    );

    // Hold the segment description captured at the last start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            err_q <= 1'b0;
        end else if (start_i) begin
            cfg_q <= dec_cfg;
            err_q <= !dec_cfg.ok;
        end
    end

    fevt_drain_track #(.DEPTH(DEPTH)) u_drain (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (start_i),
        .wr_i        (wr_i),
        .rd_i        (rd_i),
        .seg_words_i (cfg_q.words),
        .seg_done_o  (seg_done)
    );

    fevt_sched #(.FRAME_W(FRAME_W), .DEPTH(DEPTH)) u_sched (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .new_ok_i      (dec_cfg.ok),
        .new_quad_i    (dec_cfg.quad),
        .cur_cfg_i     (cfg_q),
        .frame_words_i (frame_words_i),
        .seg_done_i    (seg_done),
        .evt_o         (evt_o)
    );

    assign seg_words_o = SEG_W'(cfg_q.words);
    assign quad_mode_o = cfg_q.quad;
    assign cfg_err_o   = err_q;
endmodule

// File: rtl/fifo_evt_gen_chk.sv
// Property checker for fifo_evt_gen. It keeps its own record of the
// frame total and the requested words, built from the ports alone.
module fifo_evt_gen_chk #(
    parameter int DEPTH   = 32,
    parameter int FRAME_W = 16,
    parameter int SEG_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [FRAME_W-1:0] frame_words_i,
    input logic               evt_o,
    input logic [SEG_W-1:0]   seg_words_o,
    input logic               quad_mode_o,
    input logic               cfg_err_o
);
    logic               started_q;
    logic [FRAME_W-1:0] frame_q;
    logic [FRAME_W:0]   req_q;

    // Shadow of the frame total and the words requested so far.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started_q <= 1'b0;
            frame_q   <= '0;
            req_q     <= '0;
        end else if (start_i) begin
            started_q <= 1'b1;
            frame_q   <= frame_words_i;
            req_q     <= '0;
        end else if (evt_o) begin
            req_q <= req_q + (FRAME_W + 1)'(seg_words_o);
        end
    end

    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> !evt_o); // R8
    AST_NO_EVT_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> started_q); // R11
    AST_EVT_WITHIN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> (req_q < (FRAME_W + 1)'(frame_q))); // R7
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> !evt_o); // R3
    AST_ERR_NO_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> (seg_words_o == '0)); // R3
    AST_SEG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_words_o == '0) || (seg_words_o == SEG_W'(DEPTH / 4)) ||
        (seg_words_o == SEG_W'(DEPTH / 2))); // R2
    AST_QUAD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        quad_mode_o == (seg_words_o == SEG_W'(DEPTH / 4))); // R2
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !evt_o); // R10
endmodule

bind fifo_evt_gen fifo_evt_gen_chk #(
    .DEPTH   (DEPTH),
    .FRAME_W (FRAME_W),
    .SEG_W   (SEG_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .frame_words_i (frame_words_i),
    .evt_o         (evt_o),
    .seg_words_o   (seg_words_o),
    .quad_mode_o   (quad_mode_o),
    .cfg_err_o     (cfg_err_o)
);

// File: tb/tb_fifo_evt_gen.sv
// Self-checking bench for fifo_evt_gen: a vector table of configurations,
// then directed tests for reset, draining, frame cap and restart.
module tb_fifo_evt_gen;
    localparam int DEPTH   = 32;
    localparam int FRAME_W = 16;
    localparam int SEG_W   = 5;
    localparam int MAX_CYC = 200000;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               start_i;
    logic [1:0]         rate_sel_i;
    logic [3:0]         len_code_i;
    logic [FRAME_W-1:0] frame_words_i;
    logic               wr_i;
    logic               rd_i;
    logic               evt_o;
    logic [SEG_W-1:0]   seg_words_o;
    logic               quad_mode_o;
    logic               cfg_err_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    fifo_evt_gen #(.DEPTH(DEPTH), .FRAME_W(FRAME_W)) dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i),
        .rate_sel_i (rate_sel_i), .len_code_i (len_code_i),
        .frame_words_i (frame_words_i), .wr_i (wr_i), .rd_i (rd_i),
        .evt_o (evt_o), .seg_words_o (seg_words_o),
        .quad_mode_o (quad_mode_o), .cfg_err_o (cfg_err_o)
    );

    typedef struct packed {
        logic [1:0]  rate;
        logic [3:0]  code;
        logic [15:0] frame;
        logic        err;
        logic [4:0]  seg;
        logic [2:0]  n_evt;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 4'd15, 16'd1000, 1'b0, 5'd16, 3'd2},
        '{2'd0, 4'd7,  16'd1000, 1'b0, 5'd8,  3'd4},
        '{2'd1, 4'd7,  16'd1000, 1'b0, 5'd16, 3'd2},
        '{2'd1, 4'd3,  16'd1000, 1'b0, 5'd8,  3'd4},
        '{2'd2, 4'd3,  16'd1000, 1'b0, 5'd16, 3'd2},
        '{2'd2, 4'd1,  16'd1000, 1'b0, 5'd8,  3'd4},
        '{2'd0, 4'd15, 16'd10,   1'b0, 5'd16, 3'd1},
        '{2'd0, 4'd7,  16'd20,   1'b0, 5'd8,  3'd3},
        '{2'd2, 4'd1,  16'd0,    1'b0, 5'd8,  3'd0},
        '{2'd0, 4'd7,  16'd32,   1'b0, 5'd8,  3'd4},
        '{2'd0, 4'd3,  16'd1000, 1'b1, 5'd0,  3'd0},
        '{2'd3, 4'd7,  16'd1000, 1'b1, 5'd0,  3'd0},
        '{2'd2, 4'd15, 16'd1000, 1'b1, 5'd0,  3'd0},
        '{2'd1, 4'd5,  16'd1000, 1'b1, 5'd0,  3'd0},
        '{2'd2, 4'd0,  16'd1000, 1'b1, 5'd0,  3'd0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_start(input logic [1:0] r, input logic [3:0] c, input logic [15:0] f);
        @(negedge clk);
        rate_sel_i    = r;
        len_code_i    = c;
        frame_words_i = f;
        start_i       = 1'b1;
        @(negedge clk);
        start_i       = 1'b0;
    endtask

    task automatic count_evts(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (evt_o) n++;
        end
    endtask

    task automatic wr_words(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_i = 1'b1;
        end
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic rd_words(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_i = 1'b1;
        end
        @(negedge clk);
        rd_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        #(20 * MAX_CYC);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", MAX_CYC, 0);
        finish_run();
    end

    initial begin
        int n;
        string tag;
        rst_n = 1'b0; start_i = 1'b0; rate_sel_i = 2'd0; len_code_i = 4'd0;
        frame_words_i = '0; wr_i = 1'b0; rd_i = 1'b0;
        repeat (3) @(negedge clk);

        // R1: reset values
        check(evt_o == 1'b0, "R1 evt", int'(evt_o), 0);
        check(seg_words_o == '0, "R1 seg", int'(seg_words_o), 0);
        check(quad_mode_o == 1'b0, "R1 quad", int'(quad_mode_o), 0);
        check(cfg_err_o == 1'b0, "R1 err", int'(cfg_err_o), 0);

        // R11: no events before the first start, even with FIFO traffic
        rst_n = 1'b1;
        wr_words(16);
        rd_words(16);
        count_evts(4, n);
        check(n == 0, "R11 events before start", n, 0);

        // Vector table: configuration decode, initial burst and cap
        for (int v = 0; v < NV; v++) begin
            do_start(VECS[v].rate, VECS[v].code, VECS[v].frame);
            check(cfg_err_o == VECS[v].err, "R3 err flag", int'(cfg_err_o), int'(VECS[v].err));
            check(seg_words_o == VECS[v].seg, "R2 seg words", int'(seg_words_o), int'(VECS[v].seg));
            check(quad_mode_o == (VECS[v].seg == 5'd8), "R2 quad mode",
                  int'(quad_mode_o), int'(VECS[v].seg == 5'd8));
            count_evts(14, n);
            if (VECS[v].err) tag = "R3 event count";
            else if (VECS[v].n_evt < ((VECS[v].seg == 5'd8) ? 3'd4 : 3'd2)) tag = "R7 event count";
            else if (VECS[v].seg == 5'd8) tag = "R5 event count";
            else tag = "R4 event count";
            check(n == int'(VECS[v].n_evt), tag, n, int'(VECS[v].n_evt));
        end

        // R5: first event timing after start (quarter mode)
        @(negedge clk);
        rate_sel_i = 2'd0; len_code_i = 4'd7; frame_words_i = 16'd1000; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(evt_o == 1'b0, "R10 quiet after start", int'(evt_o), 0);
        @(negedge clk);
        check(evt_o == 1'b1, "R5 first event", int'(evt_o), 1);
        @(negedge clk);
        check(evt_o == 1'b0, "R8 gap after event", int'(evt_o), 0);
        count_evts(10, n);
        check(n == 3, "R5 remaining burst", n, 3);

        // R9: reads on an empty FIFO are ignored
        rd_words(8);
        count_evts(4, n);
        check(n == 0, "R9 empty reads", n, 0);

        // R6: a full segment drain raises an event two edges after the last read
        wr_words(8);
        rd_words(8);
        check(evt_o == 1'b0, "R6 not yet", int'(evt_o), 0);
        @(negedge clk);
        check(evt_o == 1'b1, "R6 drain event", int'(evt_o), 1);
        @(negedge clk);
        check(evt_o == 1'b0, "R8 single pulse", int'(evt_o), 0);

        // R6: a partly drained segment raises nothing, completing it does
        wr_words(8);
        rd_words(7);
        count_evts(4, n);
        check(n == 0, "R6 partial drain", n, 0);
        rd_words(1);
        count_evts(4, n);
        check(n == 1, "R6 completed drain", n, 1);

        // R7: frame of 40 words in quarter mode gives 5 events in total
        do_start(2'd0, 4'd7, 16'd40);
        count_evts(14, n);
        check(n == 4, "R7 initial burst", n, 4);
        wr_words(8);
        rd_words(8);
        count_evts(6, n);
        check(n == 1, "R7 last needed event", n, 1);
        wr_words(8);
        rd_words(8);
        count_evts(6, n);
        check(n == 0, "R7 no excess event", n, 0);

        // R10: restart mid-burst issues the full initial burst again
        do_start(2'd0, 4'd7, 16'd1000);
        count_evts(3, n);
        check(n == 2, "R10 before restart", n, 2);
        do_start(2'd1, 4'd7, 16'd1000);
        count_evts(14, n);
        check(n == 2, "R10 restart burst", n, 2);
        check(seg_words_o == 5'd16, "R10 new config", int'(seg_words_o), 16);

        finish_run();
    end
endmodule